// File: doc/BRIEF.md
# Bidirectional Comma-Marking Code Decoder

The block decodes a stored binary message written with the fixed variable-length code whose five words are 11, 011, 001, 01 and 00. This code can always be decoded in only one way, but some words are prefixes of others. For example, 01 begins 011 and 00 begins 001. A single left-to-right prefix matcher therefore cannot commit to a word as soon as it sees one.

The block makes two scans over the message.
- A forward scan marks every bit boundary at which the bits before it split fully into code words.
- A reverse scan marks every boundary at which the bits after it split fully into code words.

A boundary carrying both marks is a true word boundary. The intersection of the two mark vectors gives the final boundary mask. An emitter then walks that mask from the start of the message and streams one symbol index per cycle.

A message of up to 32 bits is presented with its length and captured on a load pulse. Bit i of the message input is the i-th bit in time order. Boundary i lies between message bits i-1 and i. Boundary 0 is the start of the message and boundary n is its end.

Top module: `comma_decoder`

## Requirements
- R1: While reset is applied, and after it is released with no load, `busy`, `done`, `sym_valid` and `parse_err` are all 0.
- R2: Symbol indices follow this table: 11 gives 0, 011 gives 1, 001 gives 2, 01 gives 3, 00 gives 4. They are emitted in message order on `sym_idx`, one per cycle on consecutive cycles, each qualified by `sym_valid`.
- R3: When `done` rises after a parsable message of length n, `bound_mask` bit i is 1 exactly when boundary i lies between two words of the unique decomposition. Bits 0 and n are set, and every bit above n is 0.
- R4: A boundary that splits only the prefix or only the suffix does not appear in `bound_mask`. For example, message 0011 gives boundaries {0,2,4}, and boundary 3 is absent.
- R5: If the whole message cannot be split into code words, `done` rises with `parse_err` = 1 and no symbol is emitted. `parse_err` is cleared by the next accepted load.
- R6: A `load` pulse while `busy` is 1 is ignored. The message in progress yields its own symbols and mask.
- R7: Counting edges from the clock edge that samples the load, `done` is a one-cycle pulse registered at edge n+k+2 for a parsable message that emits k symbols. On a parse error it is registered at edge n+1.
- R8: The 19-bit message 0011101100011010011 decodes to the indices 2,0,1,4,1,3,4,0.
- R9: `sym_valid` is 0 whenever `busy` is 0, and `done` never stays high for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load | input | 1 | Capture the message and its length when idle |
| msg_bits | input | 32 | Message, bit i is the i-th bit in time order |
| msg_len | input | 6 | Message length in bits, 0 to 32 |
| busy | output | 1 | A message is being scanned or emitted |
| done | output | 1 | One-cycle pulse at the end of a message |
| parse_err | output | 1 | Message has no decomposition, held until the next load |
| bound_mask | output | 33 | Final boundary mask, valid from `done` until the next load |
| sym_valid | output | 1 | `sym_idx` carries a decoded symbol |
| sym_idx | output | 3 | Decoded symbol index |

## Verification
The forward and reverse scans update their mark vectors in the same cycles and cross in the middle of the message. Even and odd lengths both occur, so the two scans reach neighbouring positions in the same cycle. Each pass must read only marks its own direction has already settled. The scoreboard judges this through the final mask and the symbol stream. A second load is also pulsed while the scans run, so capture and scanning share a cycle. That run must still produce exactly the first message's symbols, mask and latency.

// File: rtl/comma_pkg.sv
package comma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EMIT = 2'd2
  } dec_state_t;

  // two-bit words: 11, 01, 00 (everything but 10)
  function automatic logic pair_ok(input logic a, input logic b);
    return !(a && !b);
  endfunction

  // three-bit words: 011, 001 (first bit 0, last bit 1)
  function automatic logic trio_ok(input logic a, input logic b, input logic c);
    return !a && c;
  endfunction

  // symbol index of the word starting with a,b(,c)
  function automatic logic [2:0] word_index(input logic is3, input logic a,
                                            input logic b, input logic c);
    logic [2:0] r;
    if (is3) r = b ? 3'd1 : 3'd2;
    else if (a) r = 3'd0;
    else r = b ? 3'd3 : 3'd4;
    return r;
  endfunction

endpackage

// File: rtl/comma_scan.sv
module comma_scan
  import comma_pkg::*;
#(
  parameter int PW  = 6,
  parameter bit REV = 1'b0,
  localparam int BW = 1 << PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] len,
  input  logic [BW-1:0] bits,
  output logic          run,
  output logic [BW-1:0] marks
);

  logic [PW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] mk_q, mk_d;
  logic [PW-1:0] pos;
  logic [PW-1:0] anchor;
  logic          hit;

  assign run   = (cnt_q != '0);
  assign marks = mk_q;

  generate
    if (!REV) begin : g_fwd
      // position being decided: 1 .. len
      assign pos    = len - cnt_q + PW'(1);
      assign anchor = '0;
      always_comb begin
        hit = 1'b0;
        if (pos >= PW'(2) && mk_q[pos-PW'(2)] &&
            pair_ok(bits[pos-PW'(2)], bits[pos-PW'(1)]))
          hit = 1'b1;
        if (pos >= PW'(3) && mk_q[pos-PW'(3)] &&
            trio_ok(bits[pos-PW'(3)], bits[pos-PW'(2)], bits[pos-PW'(1)]))
          hit = 1'b1;
      end
    end else begin : g_rev
      // position being decided: len-1 .. 0
      assign pos    = cnt_q - PW'(1);
      assign anchor = len;
      always_comb begin
        hit = 1'b0;
        if (mk_q[pos+PW'(2)] && pair_ok(bits[pos], bits[pos+PW'(1)]))
          hit = 1'b1;
        if (mk_q[pos+PW'(3)] &&
            trio_ok(bits[pos], bits[pos+PW'(1)], bits[pos+PW'(2)]))
          hit = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    mk_d  = mk_q;
    if (start) begin
      cnt_d        = len;
      mk_d         = '0;
      mk_d[anchor] = 1'b1;
    end else if (run) begin
      cnt_d     = cnt_q - PW'(1);
      mk_d[pos] = hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mk_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      mk_q  <= mk_d;
    end
  end

  // the end a pass starts from stays marked while the pass runs
  p_anchor_kept_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    run |-> mk_q[anchor]);

endmodule

// File: rtl/comma_emit.sv
module comma_emit
  import comma_pkg::*;
#(
  parameter int PW  = 6,
  localparam int BW = 1 << PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] len,
  input  logic [BW-1:0] fin,
  input  logic [BW-1:0] bits,
  output logic          act,
  output logic          sym_valid,
  output logic [2:0]    sym_idx
);

  logic [PW-1:0] cur_q, cur_d;
  logic          act_q, act_d;
  logic          vld_q, vld_d;
  logic [2:0]    sym_q, sym_d;
  logic          long_w;

  assign act       = act_q;
  assign sym_valid = vld_q;
  assign sym_idx   = sym_q;

  // the next word is three bits long when the two-bit boundary is not kept
  assign long_w = !fin[cur_q+PW'(2)];

  always_comb begin
    cur_d = cur_q;
    act_d = act_q;
    vld_d = 1'b0;
    sym_d = sym_q;
    if (start) begin
      cur_d = '0;
      act_d = (len != '0);
    end else if (act_q) begin
      cur_d = cur_q + (long_w ? PW'(3) : PW'(2));
      act_d = (cur_d < len);
      vld_d = 1'b1;
      sym_d = word_index(long_w, bits[cur_q], bits[cur_q+PW'(1)],
                         bits[cur_q+PW'(2)]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      act_q <= 1'b0;
      vld_q <= 1'b0;
      sym_q <= '0;
    end else begin
      cur_q <= cur_d;
      act_q <= act_d;
      vld_q <= vld_d;
      sym_q <= sym_d;
    end
  end

  // exactly one of the two candidate next boundaries survives intersection
  p_one_step_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (fin[cur_q+PW'(2)] != fin[cur_q+PW'(3)]));

endmodule

// File: rtl/comma_decoder.sv
module comma_decoder
  import comma_pkg::*;
#(
  parameter int MAXN = 32,
  localparam int LW  = $clog2(MAXN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MAXN-1:0] msg_bits,
  input  logic [LW-1:0]   msg_len,
  output logic            busy,
  output logic            done,
  output logic            parse_err,
  output logic [MAXN:0]   bound_mask,
  output logic            sym_valid,
  output logic [2:0]      sym_idx
);

  // room for len+3 so that look-ahead indices never leave the vectors
  localparam int PW = $clog2(MAXN + 3);
  localparam int BW = 1 << PW;

  logic [1:0]    rs_q;
  logic          rst_ns;
  dec_state_t    st_q, st_d;
  logic [BW-1:0] bits_q, bits_d;
  logic [PW-1:0] len_q, len_d;
  logic          err_q, err_d;
  logic          done_q, done_d;
  logic          cap_en, emit_go;
  logic [PW-1:0] scan_len;
  logic          fw_run, rv_run;
  logic [BW-1:0] lo_mk, up_mk, fin;
  logic          em_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  assign cap_en   = load && (st_q == ST_IDLE);
  assign scan_len = cap_en ? PW'(msg_len) : len_q;
  assign fin      = lo_mk & up_mk;

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign parse_err  = err_q;
  assign bound_mask = fin[MAXN:0];

  always_comb begin
    st_d    = st_q;
    bits_d  = bits_q;
    len_d   = len_q;
    err_d   = err_q;
    done_d  = 1'b0;
    emit_go = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cap_en) begin
          st_d   = ST_SCAN;
          bits_d = BW'(msg_bits);
          len_d  = PW'(msg_len);
          err_d  = 1'b0;
        end
      end
      ST_SCAN: begin
        if (!fw_run && !rv_run) begin
          if (!lo_mk[len_q]) begin
            st_d   = ST_IDLE;
            err_d  = 1'b1;
            done_d = 1'b1;
          end else begin
            st_d    = ST_EMIT;
            emit_go = 1'b1;
          end
        end
      end
      ST_EMIT: begin
        if (!em_act) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= ST_IDLE;
      bits_q <= '0;
      len_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      done_q <= done_d;
      if (cap_en) begin
        bits_q <= bits_d;
        len_q  <= len_d;
      end
    end
  end

  comma_scan #(.PW(PW), .REV(1'b0)) u_fwd (
    .clk(clk), .rst_n(rst_ns), .start(cap_en), .len(scan_len),
    .bits(bits_q), .run(fw_run), .marks(lo_mk)
  );

  comma_scan #(.PW(PW), .REV(1'b1)) u_rev (
    .clk(clk), .rst_n(rst_ns), .start(cap_en), .len(scan_len),
    .bits(bits_q), .run(rv_run), .marks(up_mk)
  );

  comma_emit #(.PW(PW)) u_emit (
    .clk(clk), .rst_n(rst_ns), .start(emit_go), .len(len_q),
    .fin(fin), .bits(bits_q), .act(em_act),
    .sym_valid(sym_valid), .sym_idx(sym_idx)
  );

  p_quiet_idle_r9 : assert property (@(posedge clk) disable iff (!rst_ns)
    !busy |-> !sym_valid);

  p_done_pulse_r9 : assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);

  p_load_ignored_r6 : assert property (@(posedge clk) disable iff (!rst_ns)
    (busy && load) |=> ($stable(len_q) && $stable(bits_q)));

  p_err_silent_r5 : assert property (@(posedge clk) disable iff (!rst_ns)
    parse_err |-> !sym_valid);

  p_scans_paired_r7 : assert property (@(posedge clk) disable iff (!rst_ns)
    fw_run == rv_run);

endmodule

// File: tb/sim_comma_decoder.sv
module sim_comma_decoder;
  localparam int CLK_P = 10;
  localparam int MAXN  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [31:0]   msg_bits = '0;
  logic [5:0]    msg_len = '0;
  logic          busy, done, parse_err, sym_valid;
  logic [32:0]   bound_mask;
  logic [2:0]    sym_idx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int load_cyc = 0;
  int exp_lat = 0;
  int exp_q[$];
  logic [32:0] exp_mask = '0;
  bit  exp_err = 1'b0;
  bit  got_done = 1'b0;
  bit  finished = 1'b0;
  string mask_tag = "R3";
  int  popped;

  comma_decoder #(.MAXN(MAXN)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .msg_bits(msg_bits),
    .msg_len(msg_len), .busy(busy), .done(done), .parse_err(parse_err),
    .bound_mask(bound_mask), .sym_valid(sym_valid), .sym_idx(sym_idx)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic string word_of(input int s);
    case (s)
      0: return "11";
      1: return "011";
      2: return "001";
      3: return "01";
      default: return "00";
    endcase
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (sym_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected symbol", sym_idx, 7);
        else begin
          popped = exp_q.pop_front();
          chk(sym_idx == popped[2:0], "R2", "symbol index", sym_idx, popped);
        end
      end
      if (done) begin
        chk(parse_err == exp_err, "R5", "parse error flag", parse_err, exp_err);
        if (!exp_err)
          chk(bound_mask == exp_mask, mask_tag, "boundary mask", bound_mask, exp_mask);
        chk(exp_q.size() == 0, "R2", "symbols left over", exp_q.size(), 0);
        chk(cyc - load_cyc == exp_lat, "R7", "done latency", cyc - load_cyc, exp_lat);
        got_done = 1'b1;
      end
    end
  end

  task automatic drive(input logic [31:0] b, input int n, input bit poke);
    @(negedge clk);
    got_done = 1'b0;
    msg_bits = b;
    msg_len  = 6'(n);
    load     = 1'b1;
    @(posedge clk);
    #1 load_cyc = cyc;
    @(negedge clk);
    load = 1'b0;
    if (poke) begin
      chk(busy == 1'b1, "R6", "busy before second load", busy, 1);
      msg_bits = ~b;
      msg_len  = 6'd5;
      load     = 1'b1;
      @(negedge clk);
      load = 1'b0;
    end
    while (!got_done) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R9", "idle after done", busy, 0);
    chk(done == 1'b0, "R9", "done single cycle", done, 0);
  endtask

  task automatic encode(input int s[$], output logic [31:0] b, output int n,
                        output logic [32:0] m);
    string w;
    b = '0; m = '0; n = 0;
    m[0] = 1'b1;
    foreach (s[k]) begin
      w = word_of(s[k]);
      for (int j = 0; j < w.len(); j++) begin
        b[n] = (w[j] == "1");
        n++;
      end
      m[n] = 1'b1;
    end
  endtask

  task automatic run_syms(input int s[$], input bit poke, input string tag);
    logic [31:0] b;
    int n;
    logic [32:0] m;
    encode(s, b, n, m);
    foreach (s[k]) exp_q.push_back(s[k]);
    exp_mask = m;
    exp_err  = 1'b0;
    exp_lat  = n + s.size() + 2;
    mask_tag = tag;
    drive(b, n, poke);
  endtask

  task automatic run_bad(input logic [31:0] b, input int n);
    exp_err  = 1'b1;
    exp_lat  = n + 1;
    mask_tag = "R5";
    drive(b, n, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rb;
    int rn;
    logic [32:0] rm;
    logic [31:0] lit;
    string ref_s;

    repeat (3) @(negedge clk);
    // R1 during reset
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(sym_valid == 1'b0, "R1", "sym_valid in reset", sym_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(parse_err == 1'b0, "R1", "parse_err after reset", parse_err, 0);
    chk(sym_valid == 1'b0, "R1", "sym_valid after reset", sym_valid, 0);

    // R8 reference message
    ref_s = "0011101100011010011";
    lit = '0;
    for (int i = 0; i < ref_s.len(); i++) lit[i] = (ref_s[i] == "1");
    encode('{2, 0, 1, 4, 1, 3, 4, 0}, rb, rn, rm);
    chk(rb == lit && rn == 19, "R8", "reference encoding", rb, lit);
    run_syms('{2, 0, 1, 4, 1, 3, 4, 0}, 1'b0, "R8");

    // R4 prefix-only boundary 3 must vanish
    run_syms('{4, 0}, 1'b0, "R4");
    run_syms('{3, 1, 4, 2}, 1'b0, "R4");

    // R2 every word alone
    for (int s = 0; s < 5; s++) run_syms('{s}, 1'b0, "R2");

    // R3 full length, even and odd word mixes
    run_syms('{3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3}, 1'b0, "R3");
    run_syms('{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0}, 1'b0, "R3");
    run_syms('{2, 4, 2, 0, 1, 3, 2, 4, 0, 1, 4}, 1'b0, "R3");

    // R6 load pulse while busy
    run_syms('{3, 2, 0}, 1'b1, "R6");

    // R5 unparsable messages
    run_bad(32'b01, 2);
    run_bad(32'b1, 1);
    run_bad(32'b0100, 4);
    // R5 flag clears on next load
    run_syms('{0, 4}, 1'b0, "R5");
    chk(parse_err == 1'b0, "R5", "flag cleared", parse_err, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule